// File: doc/BRIEF.md
# Folded Word Memory with Column Selection

This block is a synchronous single-port memory of 2^n words, each 2^m bits wide, whose storage is laid out the way a dense array is: as 2^(n-k) physical rows, each holding 2^k words side by side, for 2^(m+k) cells per row. One access happens per clock. The address and the write enable are registered first. The upper address field then drives a predecoded row decoder. That decoder splits the row field into two-bit groups and turns each group into four lines, exactly one of them high. Each wordline is the AND of one line from every group. The low address field picks one word position inside the row.

A read enables one whole row. Every output bit then picks, through its own column multiplexer, one of the 2^k cells that share its bit position. A write changes only the cells of the addressed word and leaves the rest of the row as it was. Inside a row, bit j of word position c sits in column j*2^k + c, so the cells for one output bit are adjacent. The model describes registers and gates, not circuits. The defaults give 2048 words of 16 bits in 256 rows of 128 columns.

Top module: `fold_sram`

## Requirements
- R1: Address bits [ADDR_W-1:FOLD_LOG2] select the row and bits [FOLD_LOG2-1:0] select the word position within it; every one of the 2^ADDR_W addresses holds its own DATA_W-bit word.
- R2: When `wr_en` is 0 at rising edge A, `rd_data` shows the word at `addr` from just after rising edge A+1.
- R3: A write changes only the addressed word; the other words of the same row keep their contents.
- R4: After reset, exactly one wordline is high in every cycle.
- R5: Each two-bit group of the row field (a final one-bit group uses lines 0 and 1) drives four predecoded lines, exactly one of which is high.
- R6: Exactly one column-select line is high in every cycle after reset.
- R7: A write captured at edge A leaves `rd_data` unchanged at edge A+1.
- R8: While `rst_n` is low at a rising edge, `rd_data` becomes 0 at that edge, and any write presented during reset does not change the memory.
- R9: A read presented at the edge right after a write to the same address returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W | Word address: row field above, column field below |
| wr_en | input | 1 | 1 = write `wr_data` to `addr`, 0 = read `addr` |
| wr_data | input | 2^DATA_LOG2 | Data to write |
| rd_data | output | 2^DATA_LOG2 | Registered read data |

## Verification
An access presented before edge A is captured at A and takes effect at edge A+1, so a read result is due just after A+1 and a write's hold of `rd_data` is checked at the same point. The bench keeps a two-stage queue of its own stimuli and, at each falling edge, settles the access driven two edges earlier against a flat model. This keeps every check in the cycle where the output is due, including a read issued directly behind a write to the same word. The one-hot rules for wordlines, predecoded lines and column selects are checked at every edge after reset, while the sweeps reach every row and column position.

// File: rtl/fold_mem_pkg.sv
// Package fold_mem_pkg
// Purpose: shared helpers for the folded memory array.
// Assumes: the row decoder splits its field into two-bit groups.
package fold_mem_pkg;

    localparam int GRP_BITS = 2;
    localparam int GRP_LINES = 4;

    // Digit (0..3) that row index r carries in predecode group g.
    function automatic int group_digit(input int r, input int g);
        return (r >> (GRP_BITS * g)) & (GRP_LINES - 1);
    endfunction

endpackage

// File: rtl/fold_row_decoder.sv
// Module fold_row_decoder
// Purpose: predecoded row decoder. Each two-bit group of the row field
//          gives four one-hot lines; each wordline ANDs one line per group.
// Assumes: ROW_W >= 1; an odd ROW_W leaves a final one-bit group that
//          drives only lines 0 and 1 of its four.
module fold_row_decoder
    import fold_mem_pkg::*;
#(
    parameter int ROW_W = 8,
    localparam int NGRP = (ROW_W + 1) / 2,
    localparam int ROWS = 1 << ROW_W
) (
    input  logic [ROW_W-1:0]        row_addr,
    output logic [NGRP*GRP_LINES-1:0] pre_lines,
    output logic [ROWS-1:0]         wordline
);

    // Predecode stage: one group of four lines per address pair.
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic [1:0] fld;
        if (2 * g + 2 <= ROW_W) begin : g_pair
            assign fld = row_addr[2*g+1 -: 2];
        end else begin : g_single
            assign fld = {1'b0, row_addr[2*g]};
        end
        for (genvar v = 0; v < GRP_LINES; v++) begin : g_line
            assign pre_lines[g*GRP_LINES+v] = (fld == 2'(v));
        end
    end

    // Final stage: one AND gate per row over its predecoded lines.
    for (genvar r = 0; r < ROWS; r++) begin : g_wl
        logic [NGRP-1:0] hit;
        for (genvar g = 0; g < NGRP; g++) begin : g_in
            assign hit[g] = pre_lines[g*GRP_LINES + group_digit(r, g)];
        end
        assign wordline[r] = &hit;
    end

endmodule

// File: rtl/fold_row.sv
// Module fold_row
// Purpose: one physical row of cells. It writes the selected word slice
//          when its wordline is high, and drives its cells onto the
//          shared bitlines only while selected.
// Assumes: col_sel is one-hot; bit j of word position c is at j*FOLD + c.
module fold_row #(
    parameter int DATA_W = 16,
    parameter int FOLD = 8,
    localparam int COLS = DATA_W * FOLD
) (
    input  logic              clk,
    input  logic              wl,
    input  logic              we,
    input  logic [FOLD-1:0]   col_sel,
    input  logic [DATA_W-1:0] wd,
    output logic [COLS-1:0]   bl_drive
);

    logic [COLS-1:0] cells;

    // Cell update: only the columns of the selected word position change.
    always_ff @(posedge clk) begin
        if (wl && we) begin
            for (int j = 0; j < DATA_W; j++) begin
                for (int c = 0; c < FOLD; c++) begin
                    if (col_sel[c]) begin
                        cells[j*FOLD + c] <= wd[j];
                    end
                end
            end
        end
    end

    // Bitline drive: the row appears on the bitlines only while selected.
    assign bl_drive = wl ? cells : '0;

endmodule

// File: rtl/fold_bit_mux.sv
// Module fold_bit_mux
// Purpose: column multiplexer for one output bit. It picks one of the
//          FOLD adjacent columns with a one-hot select.
// Assumes: sel is one-hot.
module fold_bit_mux #(
    parameter int FOLD = 8
) (
    input  logic [FOLD-1:0] cols,
    input  logic [FOLD-1:0] sel,
    output logic            bit_out
);

    // Pass-gate equivalent: AND with the select, then OR the results.
    assign bit_out = |(cols & sel);

endmodule

// File: rtl/fold_sram.sv
// Module fold_sram
// Purpose: single-port folded memory. The access is registered, the
//          registered address drives the row decoder and column select,
//          and the write or the read completes on the following edge.
// Assumes: FOLD_LOG2 >= 1 and ADDR_W > FOLD_LOG2; storage is not reset.
module fold_sram #(
    parameter int ADDR_W = 11,
    parameter int DATA_LOG2 = 4,
    parameter int FOLD_LOG2 = 3,
    localparam int DATA_W = 1 << DATA_LOG2,
    localparam int FOLD = 1 << FOLD_LOG2,
    localparam int ROW_W = ADDR_W - FOLD_LOG2,
    localparam int ROWS = 1 << ROW_W,
    localparam int COLS = DATA_W * FOLD,
    localparam int NGRP = (ROW_W + 1) / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    logic [ADDR_W-1:0] addr_q;
    logic              we_q;
    logic [DATA_W-1:0] wd_q;
    logic [FOLD-1:0]   col_sel;
    logic [ROWS-1:0]   wordline;
    logic [NGRP*4-1:0] pre_lines;
    logic [COLS-1:0]   row_drive [ROWS];
    logic [COLS-1:0]   bitlines;
    logic [DATA_W-1:0] mux_word;

    // Access register: capture address, direction and data; reset blocks writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            we_q   <= 1'b0;
            wd_q   <= '0;
        end else begin
            addr_q <= addr;
            we_q   <= wr_en;
            wd_q   <= wr_data;
        end
    end

    // Column decoder: one-hot select from the low address field.
    always_comb begin
        col_sel = '0;
        col_sel[addr_q[FOLD_LOG2-1:0]] = 1'b1;
    end

    fold_row_decoder #(.ROW_W(ROW_W)) u_rowdec (
        .row_addr (addr_q[ADDR_W-1:FOLD_LOG2]),
        .pre_lines(pre_lines),
        .wordline (wordline)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        fold_row #(.DATA_W(DATA_W), .FOLD(FOLD)) u_row (
            .clk     (clk),
            .wl      (wordline[r]),
            .we      (we_q),
            .col_sel (col_sel),
            .wd      (wd_q),
            .bl_drive(row_drive[r])
        );
    end

    // Shared bitlines: wired-OR of all row drives (only one is non-zero).
    always_comb begin
        bitlines = '0;
        for (int r = 0; r < ROWS; r++) begin
            bitlines = bitlines | row_drive[r];
        end
    end

    for (genvar j = 0; j < DATA_W; j++) begin : g_bit
        fold_bit_mux #(.FOLD(FOLD)) u_mux (
            .cols   (bitlines[j*FOLD +: FOLD]),
            .sel    (col_sel),
            .bit_out(mux_word[j])
        );
    end

    // Read register: load the muxed word on read cycles, hold on writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (!we_q) begin
            rd_data <= mux_word;
        end
    end

endmodule

// File: rtl/fold_sram_chk.sv
// Module fold_sram_chk
// Purpose: protocol and decode checks for fold_sram, attached by bind.
// Assumes: connected to the top module's ports and decode nets.
module fold_sram_chk #(
    parameter int DATA_W = 16,
    parameter int ROWS = 256,
    parameter int FOLD = 8,
    parameter int NGRP = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] rd_data,
    input logic [ROWS-1:0]   wordline,
    input logic [NGRP*4-1:0] pre_lines,
    input logic [FOLD-1:0]   col_sel
);

    p_wordline_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wordline) == 1);

    for (genvar g = 0; g < NGRP; g++) begin : g_pre
        p_predec_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(pre_lines[g*4 +: 4]) == 1);
    end

    p_colsel_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(col_sel) == 1);

    p_write_holds_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en)) |=> $stable(rd_data));

    p_reset_clears_r8: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0));

endmodule

bind fold_sram fold_sram_chk #(
    .DATA_W(DATA_W),
    .ROWS  (ROWS),
    .FOLD  (FOLD),
    .NGRP  (NGRP)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_data  (rd_data),
    .wordline (wordline),
    .pre_lines(pre_lines),
    .col_sel  (col_sel)
);

// File: tb/sim_fold_sram.sv
// Bench sim_fold_sram
// Purpose: sweeps a 32-word x 4-bit configuration (8 rows of 16 columns,
//          odd row field) against a flat model settled two edges late.
`timescale 1ns/1ps
module sim_fold_sram;

    localparam int AW = 5;
    localparam int DL = 2;
    localparam int FL = 2;
    localparam int DW = 1 << DL;
    localparam int NW = 1 << AW;
    localparam int PER_ROW = 1 << FL;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int failures = 0;

    logic [DW-1:0] model [NW];
    logic [DW-1:0] exp_rd = '0;

    logic          p1_v = 1'b0, p2_v = 1'b0;
    logic          p1_we, p2_we;
    int            p1_a, p2_a;
    logic [DW-1:0] p1_d, p2_d;
    string         p1_tag, p2_tag;

    fold_sram #(.ADDR_W(AW), .DATA_LOG2(DL), .FOLD_LOG2(FL)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data)
    );

    always #2 clk = ~clk;

    task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp,
                         input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: rd_data=%h expected %h", tag, act, exp);
        end
    endtask

    // One access per cycle; settles the access driven two edges earlier.
    task automatic step(input logic we, input int a, input logic [DW-1:0] d,
                        input string tag);
        @(negedge clk);
        if (p2_v) begin
            if (p2_we) begin
                model[p2_a] = p2_d;
                check(rd_data, exp_rd, {"R7 hold after ", p2_tag});
            end else begin
                exp_rd = model[p2_a];
                check(rd_data, exp_rd, p2_tag);
            end
        end
        p2_v = p1_v; p2_we = p1_we; p2_a = p1_a; p2_d = p1_d; p2_tag = p1_tag;
        p1_v = 1'b1; p1_we = we; p1_a = a; p1_d = d; p1_tag = tag;
        wr_en = we;
        addr = a[AW-1:0];
        wr_data = d;
    endtask

    function automatic logic [DW-1:0] fill_val(input int a);
        return DW'((a * 5 + 3) ^ (a >> 2));
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not complete");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int seed;
        // R8: reset state
        repeat (3) @(negedge clk);
        check(rd_data, '0, "R8 reset value");
        rst_n = 1'b1;

        // R1: fill every address with a computed pattern
        for (int a = 0; a < NW; a++) step(1'b1, a, fill_val(a), "R1 fill");
        // R1 R2 R4 R5 R6: back-to-back reads of every address
        for (int a = 0; a < NW; a++) step(1'b0, a, '0, "R1 R2 R4 R5 R6 sweep read");

        // R3: rewrite each word, then read all words of its row
        for (int a = 0; a < NW; a++) begin
            int base;
            base = a & ~(PER_ROW - 1);
            step(1'b1, a, ~fill_val(a) ^ DW'(a >> FL), "R3 row write");
            for (int c = 0; c < PER_ROW; c++)
                step(1'b0, base + c, '0, "R3 row neighbour read");
        end

        // R9: read immediately behind a write to the same address
        for (int a = 0; a < NW; a++) begin
            step(1'b1, a, DW'(a * 3 + 1), "R9 write");
            step(1'b0, a, '0, "R9 read after write");
        end

        // R2: mixed accesses from a computed sequence
        seed = 32'h1d2c3b4a;
        for (int i = 0; i < 2000; i++) begin
            seed = seed * 1103515245 + 12345;
            step(seed[20], int'(seed[15:11]), seed[27:24], "R2 mixed access");
        end
        for (int i = 0; i < 3; i++) step(1'b0, 0, '0, "R2 flush read");

        // R8: a write presented during reset must not reach the memory
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b1;
        addr = AW'(5);
        wr_data = ~model[5];
        repeat (3) @(negedge clk);
        check(rd_data, '0, "R8 reset clears read data");
        rst_n = 1'b1;
        wr_en = 1'b0;
        p1_v = 1'b0;
        p2_v = 1'b0;
        exp_rd = '0;
        step(1'b0, 5, '0, "R8 write during reset ignored");
        for (int i = 0; i < 2; i++) step(1'b0, 6, '0, "R8 post-reset read");
        @(negedge clk);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule